// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block supplies the two ALU operands of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). For each source register of the instruction now in execute, it compares the register number with the destinations recorded in the two later pipeline registers. Those are the execute/memory register, which holds the newest ALU result, and the memory/write-back register, which holds the older result or the data returned from memory. The operand comes from whichever of them will write that register. If neither does, the operand is the value read from the register file in decode. When both stages will write the register, the younger one, execute/memory, wins.

The block also finds the one dependence that bypassing cannot hide. A load is in execute and the instruction behind it in decode reads the loaded register. In that case the block raises a stall request. The surrounding pipeline then freezes the PC and the fetch/decode register and puts a bubble, with every write-enable cleared, into execute. The unit is purely combinational. The register file, ALU and pipeline registers are outside it. Write-after-read and write-after-write ordering is not handled here, because reads and writes stay in program order. A producer three instructions ahead is covered by the register file writing before it reads in the same cycle, which is also outside this block.

Top module: `operand_bypass`

## Requirements
- R1: When the execute/memory entry has its write-enable high and a non-zero destination equal to an operand's source, the operand equals that entry's result and its select code is 2'b10.
- R2: When only the memory/write-back entry matches an operand's source (write-enable high, non-zero destination equal to the source), the operand equals that entry's value and its select code is 2'b01.
- R3: When both entries match the same source, the execute/memory result is chosen (code 2'b10).
- R4: When no entry matches, the operand is the register-file value read in decode and the select code is 2'b00.
- R5: Source register 0 is never forwarded, even when an entry with write-enable high names destination 0. Its operand is the register-file value with code 2'b00.
- R6: An entry whose write-enable is low never supplies an operand, whatever its destination field holds.
- R7: Operands A and B are each selected only from their own source number. A match on one source does not change the other operand.
- R8: The stall request is high when the instruction in execute is a load with write-enable high and non-zero destination, and that destination equals a decode-stage source whose use flag is set.
- R9: The stall request is low when the execute instruction is not a load, when its write-enable is low, when its destination is 0, or when the matching decode source has its use flag clear.
- R10: All outputs follow the inputs within the same cycle, with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | RW | First source register of the execute instruction |
| ex_src_b | input | RW | Second source register of the execute instruction |
| rf_val_a | input | XLEN | Register-file value read for the first source |
| rf_val_b | input | XLEN | Register-file value read for the second source |
| em_dst | input | RW | Destination held in the execute/memory register |
| em_wen | input | 1 | Write-enable held in the execute/memory register |
| em_res | input | XLEN | ALU result held in the execute/memory register |
| mw_dst | input | RW | Destination held in the memory/write-back register |
| mw_wen | input | 1 | Write-enable held in the memory/write-back register |
| mw_res | input | XLEN | Result or load data held in the memory/write-back register |
| ex_dst | input | RW | Destination of the execute instruction |
| ex_wen | input | 1 | Write-enable of the execute instruction |
| ex_load | input | 1 | Execute instruction is a load |
| id_src_a | input | RW | First source of the decode instruction |
| id_src_b | input | RW | Second source of the decode instruction |
| id_use_a | input | 1 | Decode instruction reads its first source |
| id_use_b | input | 1 | Decode instruction reads its second source |
| op_a | output | XLEN | Selected first ALU operand |
| op_b | output | XLEN | Selected second ALU operand |
| sel_a | output | 2 | Source of op_a: 00 register file, 01 memory/write-back, 10 execute/memory |
| sel_b | output | 2 | Source of op_b, same encoding |
| stall_req | output | 1 | Load-use interlock request |

## Verification
The assertions assume that every input is a settled two-state value whenever they are evaluated. They also assume that a bubble appears only as an entry with its write-enable cleared, never as a special destination code. The stimulus drives every input in one step, away from the sampling point. It draws register numbers from a small range so that matches, double matches and register 0 occur often. Write-enable, load and use flags are drawn independently, so that entries which are disabled but still match show up in every combination.

// File: rtl/operand_bypass.sv
module operand_bypass #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic [RW-1:0]   ex_src_a,
  input  logic [RW-1:0]   ex_src_b,
  input  logic [XLEN-1:0] rf_val_a,
  input  logic [XLEN-1:0] rf_val_b,
  input  logic [RW-1:0]   em_dst,
  input  logic            em_wen,
  input  logic [XLEN-1:0] em_res,
  input  logic [RW-1:0]   mw_dst,
  input  logic            mw_wen,
  input  logic [XLEN-1:0] mw_res,
  input  logic [RW-1:0]   ex_dst,
  input  logic            ex_wen,
  input  logic            ex_load,
  input  logic [RW-1:0]   id_src_a,
  input  logic [RW-1:0]   id_src_b,
  input  logic            id_use_a,
  input  logic            id_use_b,
  output logic [XLEN-1:0] op_a,
  output logic [XLEN-1:0] op_b,
  output logic [1:0]      sel_a,
  output logic [1:0]      sel_b,
  output logic            stall_req
);

  localparam logic [1:0] SEL_RF = 2'b00;
  localparam logic [1:0] SEL_MW = 2'b01;
  localparam logic [1:0] SEL_EM = 2'b10;

  logic [RW-1:0]   src [2];
  logic [XLEN-1:0] rfv [2];
  logic [XLEN-1:0] val [2];
  logic [1:0]      sel [2];

  assign src[0] = ex_src_a;
  assign src[1] = ex_src_b;
  assign rfv[0] = rf_val_a;
  assign rfv[1] = rf_val_b;

  for (genvar g = 0; g < 2; g++) begin : g_op
    logic          hit_em, hit_mw;
    logic [1:0]    s;
    logic [XLEN-1:0] v;

    always_comb begin
      hit_em = em_wen && (em_dst != '0) && (em_dst == src[g]);
      hit_mw = mw_wen && (mw_dst != '0) && (mw_dst == src[g]);
      if (hit_em) begin
        s = SEL_EM;
        v = em_res;
      end else if (hit_mw) begin
        s = SEL_MW;
        v = mw_res;
      end else begin
        s = SEL_RF;
        v = rfv[g];
      end

      // R5
      zero_src_chk: assert (src[g] != '0 || s == SEL_RF);
      // R6
      em_enable_chk: assert (s != SEL_EM || em_wen);
      // R6
      mw_enable_chk: assert (s != SEL_MW || mw_wen);
      // R3
      younger_wins_chk: assert (s != SEL_MW || !(em_wen && em_dst == src[g]));
      // R1
      em_value_chk: assert (s != SEL_EM || v == em_res);
      // R2
      mw_value_chk: assert (s != SEL_MW || v == mw_res);
      // R4
      rf_value_chk: assert (s != SEL_RF || v == rfv[g]);
    end

    assign sel[g] = s;
    assign val[g] = v;
  end

  assign op_a  = val[0];
  assign op_b  = val[1];
  assign sel_a = sel[0];
  assign sel_b = sel[1];

  logic load_live, need_a, need_b, stall_c;

  always_comb begin
    load_live = ex_load && ex_wen && (ex_dst != '0);
    need_a    = id_use_a && (id_src_a == ex_dst);
    need_b    = id_use_b && (id_src_b == ex_dst);
    stall_c   = load_live && (need_a || need_b);
    // R9
    stall_load_chk: assert (!stall_c || (ex_load && ex_wen));
    // R9
    stall_zero_chk: assert (!stall_c || ex_dst != '0);
    // R8
    stall_cause_chk: assert (!stall_c || (id_use_a && id_src_a == ex_dst)
                                      || (id_use_b && id_src_b == ex_dst));
  end

  assign stall_req = stall_c;

endmodule

// File: tb/tb_operand_bypass.sv
module tb_operand_bypass;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RW = 5;

  logic clk = 0;
  logic rst = 1;
  always #2.5 clk = ~clk;

  logic [RW-1:0] ex_src_a, ex_src_b, em_dst, mw_dst, ex_dst, id_src_a, id_src_b;
  logic [XLEN-1:0] rf_val_a, rf_val_b, em_res, mw_res;
  logic em_wen, mw_wen, ex_wen, ex_load, id_use_a, id_use_b;
  logic [XLEN-1:0] op_a, op_b;
  logic [1:0] sel_a, sel_b;
  logic stall_req;

  operand_bypass #(.XLEN(XLEN), .NREG(NREG)) dut (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
    .em_dst(em_dst), .em_wen(em_wen), .em_res(em_res),
    .mw_dst(mw_dst), .mw_wen(mw_wen), .mw_res(mw_res),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_use_a(id_use_a), .id_use_b(id_use_b),
    .op_a(op_a), .op_b(op_b), .sel_a(sel_a), .sel_b(sel_b), .stall_req(stall_req)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int pick(int src, logic ew, int ed, logic mwe, int md);
    if (src == 0) return 0;
    if (ew && ed == src) return 2;
    if (mwe && md == src) return 1;
    return 0;
  endfunction

  task automatic compare(string tag);
    int sa, sb;
    logic [XLEN-1:0] ea, eb;
    logic es;
    sa = pick(ex_src_a, em_wen, em_dst, mw_wen, mw_dst);
    sb = pick(ex_src_b, em_wen, em_dst, mw_wen, mw_dst);
    ea = (sa == 2) ? em_res : (sa == 1) ? mw_res : rf_val_a;
    eb = (sb == 2) ? em_res : (sb == 1) ? mw_res : rf_val_b;
    es = ex_load && ex_wen && ex_dst != 0 &&
         ((id_use_a && id_src_a == ex_dst) || (id_use_b && id_src_b == ex_dst));
    check({tag, " op_a"}, op_a, ea);
    check({tag, " sel_a"}, sel_a, sa[1:0]);
    check({tag, " op_b"}, op_b, eb);
    check({tag, " sel_b"}, sel_b, sb[1:0]);
    check({tag, " stall"}, stall_req, es);
  endtask

  task automatic clear();
    ex_src_a = 0; ex_src_b = 0; em_dst = 0; mw_dst = 0; ex_dst = 0;
    id_src_a = 0; id_src_b = 0;
    rf_val_a = 32'hA0A0_0001; rf_val_b = 32'hB0B0_0002;
    em_res = 32'hE0E0_0003; mw_res = 32'hF0F0_0004;
    em_wen = 0; mw_wen = 0; ex_wen = 0; ex_load = 0; id_use_a = 0; id_use_b = 0;
  endtask

  task automatic step_check(string tag);
    @(negedge clk);
    compare(tag);
    @(posedge clk);
    #1;
  endtask

  initial begin
    clear();
    repeat (3) @(posedge clk);
    rst = 0;
    #1;
    step_check("R4 reset");

    clear(); ex_src_a = 3; em_wen = 1; em_dst = 3;
    step_check("R1 em hit");
    check("R1 sel code", sel_a, 2'b10);
    check("R7 other op untouched", op_b, 32'hB0B0_0002);

    clear(); ex_src_b = 4; mw_wen = 1; mw_dst = 4;
    step_check("R2 mw hit");
    check("R2 sel code", sel_b, 2'b01);

    clear(); ex_src_a = 6; ex_src_b = 6; em_wen = 1; em_dst = 6; mw_wen = 1; mw_dst = 6;
    step_check("R3 double hit");
    check("R3 em wins", op_a, 32'hE0E0_0003);

    clear(); ex_src_a = 0; em_wen = 1; em_dst = 0; mw_wen = 1; mw_dst = 0;
    step_check("R5 reg zero");
    check("R5 rf value", op_a, 32'hA0A0_0001);

    clear(); ex_src_a = 7; em_dst = 7; mw_dst = 7;
    step_check("R6 disabled entries");
    check("R6 rf value", op_a, 32'hA0A0_0001);

    clear(); ex_src_a = 2; ex_src_b = 5; em_wen = 1; em_dst = 2; mw_wen = 1; mw_dst = 5;
    step_check("R7 split sources");

    clear(); ex_load = 1; ex_wen = 1; ex_dst = 9; id_src_b = 9; id_use_b = 1;
    step_check("R8 load use");
    check("R8 stall high", stall_req, 1'b1);

    clear(); ex_load = 1; ex_wen = 1; ex_dst = 9; id_src_b = 9; id_use_b = 0;
    step_check("R9 unused source");
    check("R9 stall low", stall_req, 1'b0);

    clear(); ex_load = 1; ex_wen = 1; ex_dst = 0; id_src_a = 0; id_use_a = 1;
    step_check("R9 dest zero");

    clear(); ex_load = 0; ex_wen = 1; ex_dst = 9; id_src_a = 9; id_use_a = 1;
    step_check("R9 not load");

    clear(); ex_src_a = 8; em_wen = 1; em_dst = 8;
    #1;
    check("R10 same cycle", op_a, 32'hE0E0_0003);
    em_res = 32'h1234_5678;
    #1;
    check("R10 follows input", op_a, 32'h1234_5678);
    @(posedge clk); #1;

    for (int i = 0; i < 3000; i++) begin
      ex_src_a = RW'($urandom_range(0, 3)); ex_src_b = RW'($urandom_range(0, 3));
      em_dst = RW'($urandom_range(0, 3)); mw_dst = RW'($urandom_range(0, 3));
      ex_dst = RW'($urandom_range(0, 3));
      id_src_a = RW'($urandom_range(0, 3)); id_src_b = RW'($urandom_range(0, 3));
      rf_val_a = $urandom; rf_val_b = $urandom; em_res = $urandom; mw_res = $urandom;
      em_wen = 1'($urandom); mw_wen = 1'($urandom); ex_wen = 1'($urandom);
      ex_load = 1'($urandom); id_use_a = 1'($urandom); id_use_b = 1'($urandom);
      step_check("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule